// File: doc/BRIEF.md
# Integer Narrowing Shift-Saturate Unit

This block takes one wide integer lane and narrows it into a smaller output lane. The input lane is 16 or 32 bits wide and the output lane is 8 or 16 bits wide. The input is first widened to an internal working width, using sign or zero extension. A right shift of 0 to 31 places follows, which may round to nearest by adding half an output LSB. The shifted value is then either clamped to the range of the output or cut down to its low bits.

Two controls are independent: whether the input is read as signed, and whether the clamp range is signed. Together they give signed-to-signed, signed-to-unsigned and unsigned-to-unsigned clamping from one datapath. With the default parameters the result leaves through a register, so a value presented with `in_valid` comes out one clock later. The block is intended as one lane of a vector narrowing stage. For a strided 32-to-16 pick, the caller selects the source word and feeds it in as a normal 32-bit lane.

Top module: `narrow_sat`

## Requirements
- R1: When `src_wide`=0 the input is `din[15:0]` and `din[31:16]` has no effect on the result. When `src_wide`=1 the input is all of `din[31:0]`. If `src_signed`=1 the input is sign-extended from its width, otherwise it is zero-extended.
- R2: The extended value is shifted right by `shamt` (0 to 31). The shift is arithmetic for signed inputs and logical for unsigned inputs.
- R3: When `rnd_en`=1 and `shamt` is nonzero, 2^(shamt-1) is added before the shift. The addition is carried out at a width that cannot overflow, so 0xFFFFFFFF unsigned, shifted by 1 with rounding, gives 2^31.
- R4: With `sat_en`=1, `src_signed`=1 and `sat_signed`=1, the result is clamped to the range -2^(w-1) to 2^(w-1)-1, where w is the output width.
- R5: With `sat_en`=1, `src_signed`=1 and `sat_signed`=0, the result is clamped to the range 0 to 2^w-1. Any negative input therefore yields 0.
- R6: With `sat_en`=1 and `src_signed`=0, only the upper bound applies. A value at or above the bound becomes 2^w-1 when `sat_signed`=0, or 2^(w-1)-1 when `sat_signed`=1.
- R7: With `sat_en`=0, the result is the low w bits of the shifted value.
- R8: `dst_wide`=1 selects a 16-bit output in `dout[15:0]`. `dst_wide`=0 selects an 8-bit output in `dout[7:0]`, and in that case `dout[15:8]` is 0.
- R9: After reset, `out_valid` and `dout` are 0. With the output register in place, each accepted input produces `out_valid`=1 and its result exactly one clock later, and `dout` holds its value while no input is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input lane is valid this cycle |
| din | input | 32 | Input lane |
| src_wide | input | 1 | 1: 32-bit input, 0: 16-bit input |
| dst_wide | input | 1 | 1: 16-bit output, 0: 8-bit output |
| shamt | input | 5 | Right shift amount |
| rnd_en | input | 1 | Round to nearest before shifting |
| src_signed | input | 1 | Input is signed |
| sat_signed | input | 1 | Clamp range is signed |
| sat_en | input | 1 | 1: saturate, 0: truncate |
| out_valid | output | 1 | Result is valid |
| dout | output | 16 | Narrowed result |

## Verification
Every result is due on the clock edge that follows the edge at which its input was accepted. Reset values are checked while reset is held. The driver task applies inputs on falling edges and pushes the expected value, computed by a bench model written from the requirements, into a queue at that moment. The monitor samples `out_valid` and `dout` on the next falling edge and pops one entry per valid output. An output with an empty queue, or entries left over at the end, is reported as a failure. Streams are sent both back to back and with gaps, which exercises both the one-cycle latency and the hold behaviour.

// File: rtl/narrow_sat.sv
module narrow_sat #(
  parameter int IN_W    = 32,
  parameter int OUT_W   = 16,
  parameter int SH_W    = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  din,
  input  logic             src_wide,
  input  logic             dst_wide,
  input  logic [SH_W-1:0]  shamt,
  input  logic             rnd_en,
  input  logic             src_signed,
  input  logic             sat_signed,
  input  logic             sat_en,
  output logic             out_valid,
  output logic [OUT_W-1:0] dout
);
  localparam int IN_N  = IN_W / 2;
  localparam int OUT_N = OUT_W / 2;
  localparam int EXT_W = IN_W + 2;

  logic signed [EXT_W-1:0] ext, rnd_add, summed, shifted, hi, lo, sat_v, res;
  logic [OUT_W-1:0] dout_c;
  logic neg_in;

  assign neg_in = src_signed & (src_wide ? din[IN_W-1] : din[IN_N-1]);

  always_comb begin
    if (src_wide) ext = {{(EXT_W-IN_W){neg_in}}, din};
    else          ext = {{(EXT_W-IN_N){neg_in}}, din[IN_N-1:0]};
  end

  assign rnd_add = (rnd_en && shamt != '0) ? (EXT_W'(1) << (shamt - SH_W'(1))) : '0;
  assign summed  = ext + rnd_add;
  assign shifted = summed >>> shamt;

  always_comb begin
    if (dst_wide) hi = sat_signed ? (EXT_W'(1) << (OUT_W-1)) : (EXT_W'(1) << OUT_W);
    else          hi = sat_signed ? (EXT_W'(1) << (OUT_N-1)) : (EXT_W'(1) << OUT_N);
    lo = (src_signed && sat_signed) ? -hi : '0;
    if (shifted < lo)        sat_v = lo;
    else if (shifted >= hi)  sat_v = hi - EXT_W'(1);
    else                     sat_v = shifted;
  end

  assign res    = sat_en ? sat_v : shifted;
  assign dout_c = dst_wide ? res[OUT_W-1:0] : {{(OUT_W-OUT_N){1'b0}}, res[OUT_N-1:0]};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          dout      <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) dout <= dout_c;
        end
      end

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dout));

      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dst_wide) |=> dout[OUT_W-1:OUT_N] == '0);

      p_neg_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !sat_signed && neg_in) |=> dout == '0);

      p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0 && !sat_en && src_wide && dst_wide)
          |=> dout == $past(din[OUT_W-1:0]));

      p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !src_signed && !sat_signed && dst_wide && src_wide
         && shamt == '0 && din[IN_W-1:OUT_W] != '0) |=> dout == '1);
    end else begin : g_comb
      assign out_valid = in_valid;
      assign dout      = dout_c;
    end
  endgenerate
endmodule

// File: tb/tb_narrow_sat.sv
module tb_narrow_sat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] din = '0;
  logic src_wide = 1'b0, dst_wide = 1'b0, rnd_en = 1'b0;
  logic src_signed = 1'b0, sat_signed = 1'b0, sat_en = 1'b0;
  logic [4:0] shamt = '0;
  logic out_valid;
  logic [15:0] dout;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  narrow_sat dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din),
    .src_wide(src_wide), .dst_wide(dst_wide), .shamt(shamt), .rnd_en(rnd_en),
    .src_signed(src_signed), .sat_signed(sat_signed), .sat_en(sat_en),
    .out_valid(out_valid), .dout(dout)
  );

  function automatic logic [15:0] model(logic [31:0] d, bit sw, bit dw, int sh,
                                        bit rn, bit ss, bit ts, bit sat);
    longint v, hi, lo;
    int w;
    if (sw) v = ss ? longint'($signed(d)) : longint'({32'h0, d});
    else    v = ss ? longint'($signed(d[15:0])) : longint'({48'h0, d[15:0]});
    if (rn && sh != 0) v = v + (longint'(1) << (sh - 1));
    v = v >>> sh;
    w = dw ? 16 : 8;
    if (sat) begin
      hi = longint'(1) << (w - (ts ? 1 : 0));
      lo = (ss && ts) ? -hi : 0;
      if (ss && v < lo) v = lo;
      if (v >= hi) v = hi - 1;
    end
    return dw ? v[15:0] : {8'h00, v[7:0]};
  endfunction

  task automatic drive(string tag, logic [31:0] d, bit sw, bit dw, int sh,
                       bit rn, bit ss, bit ts, bit sat);
    @(negedge clk);
    in_valid = 1'b1; din = d; src_wide = sw; dst_wide = dw; shamt = 5'(sh);
    rnd_en = rn; src_signed = ss; sat_signed = ts; sat_en = sat;
    exp_q.push_back(model(d, sw, dw, sh, rn, ss, ts, sat));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9: output without input, actual %h expected none", dout);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dout !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, dout, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || dout !== 16'h0) begin
      failures++;
      $display("FAIL R9: reset state actual %b/%h expected 0/0000", out_valid, dout);
    end
    rst_n = 1'b1;

    drive("R1", 32'hABCD_8000, 0, 1, 0, 0, 1, 0, 0);
    drive("R1", 32'hABCD_8000, 0, 1, 4, 0, 1, 0, 0);
    drive("R1", 32'h1234_8000, 0, 1, 4, 0, 0, 0, 0);
    drive("R2", 32'h8000_0000, 1, 1, 31, 0, 1, 0, 0);
    drive("R2", 32'h8000_0000, 1, 1, 31, 0, 0, 0, 0);
    drive("R3", 32'h0000_0018, 1, 1, 4, 1, 0, 0, 0);
    drive("R3", 32'h0000_0018, 1, 1, 4, 0, 0, 0, 0);
    drive("R3", 32'hFFFF_FFFF, 1, 1, 1, 1, 0, 0, 0);
    drive("R3", 32'hFFFF_FFFF, 1, 1, 1, 1, 0, 0, 1);
    idle(2);
    checks++;
    if (dout !== 16'hFFFF) begin
      failures++;
      $display("FAIL R9: hold actual %h expected ffff", dout);
    end
    drive("R4", 32'h0001_2345, 1, 1, 0, 0, 1, 1, 1);
    drive("R4", 32'hFFFE_0000, 1, 1, 0, 0, 1, 1, 1);
    drive("R4", 32'h0000_0100, 0, 0, 0, 0, 1, 1, 1);
    drive("R4", 32'h0000_FF00, 0, 0, 0, 0, 1, 1, 1);
    drive("R4", 32'h0000_FFF0, 0, 0, 0, 0, 1, 1, 1);
    drive("R5", 32'hFFFF_FFFB, 1, 0, 0, 0, 1, 0, 1);
    drive("R5", 32'h0000_012C, 1, 0, 0, 0, 1, 0, 1);
    drive("R5", 32'h0000_0064, 1, 0, 0, 0, 1, 0, 1);
    drive("R6", 32'hFFFF_0000, 1, 1, 0, 0, 0, 1, 1);
    drive("R6", 32'h0000_8000, 1, 1, 0, 0, 0, 1, 1);
    drive("R6", 32'h0001_0000, 1, 1, 0, 0, 0, 0, 1);
    drive("R6", 32'h0000_FFFF, 1, 1, 0, 0, 0, 0, 1);
    drive("R7", 32'h1234_5678, 1, 1, 0, 0, 0, 0, 0);
    drive("R7", 32'h0000_1234, 0, 0, 0, 0, 0, 0, 0);
    drive("R8", 32'hFFFF_FF85, 1, 0, 0, 0, 1, 0, 0);
    idle(1);
    for (int i = 0; i < 400; i++) begin
      drive("R2", $urandom, 1'($urandom), 1'($urandom), int'($urandom % 32),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (i % 17 == 0) idle(1);
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9: missing outputs actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R9: watchdog actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule